// File: doc/BRIEF.md
# DMA Read Request Rate Limiter

This block sits between the data-transfer read request generator of a DMA channel and the request path toward memory. It slows that stream of reads so the channel can run as a background task that takes only a fraction of the available bandwidth. Each accepted read loads a credit counter with the request's length in DWords. The counter then drains by one every `rate_cfg` base ticks. While credit remains, the limiter withholds ready from the generator and valid from the downstream path. Descriptor fetch reads and data-transfer writes never route through this block.

The `tick` input pulses once per 4 ns base period. With a 250 MHz core clock it is tied high, so one cycle equals one tick. With `rate_cfg` = 1 a DWord of credit drains every 4 ns. With 1000 it drains every 4 µs, which limits reads to about 1 MB/s. The general figure is roughly 1000/`rate_cfg` MB/s. A `rate_cfg` of zero switches throttling off: requests pass as soon as the downstream path accepts them.

Control is a two-state machine. ST_OPEN means no credit is held and the gate is open. ST_HOLD means credit is draining and the gate is shut. Transition LOAD (ST_OPEN to ST_HOLD) fires when a non-empty request is accepted while throttling is on. Transition DRAINED (ST_HOLD to ST_OPEN) fires on the decrement that takes the credit from one to zero. Transition DISABLE (ST_HOLD to ST_OPEN) fires when `rate_cfg` becomes zero. A prescaler counts ticks up to the latched rate to make each decrement pulse, and it restarts on every LOAD.

Top module: `rd_rate_limiter`

## Requirements
- R1: While `rate_cfg` is 0, `rd_req_ready` equals `rd_dn_ready` and `rd_dn_valid` equals `rd_req_valid` in every cycle, and no credit is loaded.
- R2: A handshake (`rd_req_valid` and `rd_req_ready` both high at a rising edge) with a non-zero `rate_cfg` and a non-zero `rd_req_len` loads the credit with `rd_req_len`. `rd_req_ready` is low in the cycle after that edge.
- R3: While credit is non-zero and `rate_cfg` is non-zero, `rd_req_ready` and `rd_dn_valid` are both 0, whatever `rd_req_valid` and `rd_dn_ready` do.
- R4: The credit drops by one after each `rate_cfg` edges that see `tick` high. With `tick` held high, a request of length L at rate R keeps `rd_req_ready` low for exactly L×R cycles after the accepting edge.
- R5: Edges where `tick` is low do not advance the drain. The hold lasts as long as `tick` stays low.
- R6: An accepted request with `rd_req_len` = 0 loads no credit, and `rd_req_ready` stays high in the next cycle.
- R7: A change of `rate_cfg` to another non-zero value during a hold applies from the next decrement period. The running period and the credit already held are not reloaded.
- R8: Setting `rate_cfg` to 0 during a hold raises `rd_req_ready` in the same cycle and clears the credit. A later non-zero rate does not resume the old hold.
- R9: After reset the credit is 0 and the gate is open, so `rd_req_ready` follows `rd_dn_ready`.
- R10: The prescaler restarts on each load. A request accepted straight after a hold ends gets a full L×R hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| rate_cfg | input | RATE_W | Drain period in base ticks per DWord; 0 disables throttling |
| tick | input | 1 | Base-period pulse (4 ns units) |
| rd_req_valid | input | 1 | Read request from the generator is valid |
| rd_req_len | input | LEN_W | Length of the offered read in DWords |
| rd_req_ready | output | 1 | Limiter and downstream accept the read |
| rd_dn_valid | output | 1 | Gated valid toward the downstream request path |
| rd_dn_len | output | LEN_W | Length forwarded downstream |
| rd_dn_ready | input | 1 | Downstream request path can accept |

## Verification
The bench builds the block with the default widths: a 12-bit rate and an 11-bit length. This brings the nominal 1000-tick rate and lengths of 1024 DWords within reach, so the longest holds run for a few thousand cycles. A behavioural model runs beside the design and checks ready and valid on every clock. Targeted cases check exact hold lengths, paused ticks, a rate change in the middle of a hold, and disabling during a hold.

// File: rtl/rrl_pkg.sv
package rrl_pkg;
    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } gate_state_e;
endpackage

// File: rtl/rrl_prescaler.sv
module rrl_prescaler #(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_cfg,
    output logic              dec_pulse
);
    logic [RATE_W-1:0] presc_q;
    logic [RATE_W-1:0] rate_q;
    logic              period_end;

    // A period ends when the rate_q-th tick of the period arrives.
    assign period_end = run && tick && (presc_q == (rate_q - RATE_W'(1)));
    assign dec_pulse  = period_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            rate_q  <= '0;
        end else if (restart) begin
            presc_q <= '0;
            rate_q  <= rate_cfg;
        end else if (period_end) begin
            presc_q <= '0;
            rate_q  <= rate_cfg;    // a new rate applies from the next period
        end else if (run && tick) begin
            presc_q <= presc_q + RATE_W'(1);
        end
    end
endmodule

// File: rtl/rrl_credit_counter.sv
module rrl_credit_counter #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic [LEN_W-1:0] credit,
    output logic             credit_last
);
    logic [LEN_W-1:0] credit_q;

    assign credit      = credit_q;
    assign credit_last = dec && (credit_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else if (clear) begin
            credit_q <= '0;
        end else if (load) begin
            credit_q <= load_val;
        end else if (dec && (credit_q != '0)) begin
            credit_q <= credit_q - LEN_W'(1);
        end
    end
endmodule

// File: rtl/rrl_gate_fsm.sv
module rrl_gate_fsm
    import rrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        throttle_off,
    input  logic        accept_load,
    input  logic        credit_last,
    output gate_state_e state,
    output logic        gate_open
);
    gate_state_e state_q, state_d;

    assign state = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (accept_load && !throttle_off) state_d = ST_HOLD;      // LOAD
            ST_HOLD: if (throttle_off || credit_last) state_d = ST_OPEN;       // DISABLE / DRAINED
            default: state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        gate_open = 1'b1;
        unique case (state_q)
            ST_OPEN: gate_open = 1'b1;
            ST_HOLD: gate_open = throttle_off;
            default: gate_open = 1'b1;
        endcase
    end
endmodule

// File: rtl/rd_rate_limiter.sv
module rd_rate_limiter
    import rrl_pkg::*;
#(
    parameter int RATE_W = 12,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_cfg,
    input  logic              tick,
    input  logic              rd_req_valid,
    input  logic [LEN_W-1:0]  rd_req_len,
    output logic              rd_req_ready,
    output logic              rd_dn_valid,
    output logic [LEN_W-1:0]  rd_dn_len,
    input  logic              rd_dn_ready
);
    gate_state_e      state;
    logic             gate_open;
    logic             throttle_off;
    logic             accept_load;
    logic             dec_pulse;
    logic             credit_last;
    logic [LEN_W-1:0] credit;

    assign throttle_off = (rate_cfg == '0);
    assign rd_req_ready = rd_dn_ready && gate_open;
    assign rd_dn_valid  = rd_req_valid && gate_open;
    assign rd_dn_len    = rd_req_len;
    assign accept_load  = rd_req_valid && rd_req_ready && !throttle_off
                          && (rd_req_len != '0) && (state == ST_OPEN);

    rrl_gate_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .throttle_off (throttle_off),
        .accept_load  (accept_load),
        .credit_last  (credit_last),
        .state        (state),
        .gate_open    (gate_open)
    );

    rrl_prescaler #(.RATE_W(RATE_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept_load),
        .run       ((state == ST_HOLD) && !throttle_off),
        .tick      (tick),
        .rate_cfg  (rate_cfg),
        .dec_pulse (dec_pulse)
    );

    rrl_credit_counter #(.LEN_W(LEN_W)) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (throttle_off),
        .load        (accept_load),
        .load_val    (rd_req_len),
        .dec         (dec_pulse),
        .credit      (credit),
        .credit_last (credit_last)
    );
endmodule

// File: rtl/rrl_checker.sv
module rrl_checker #(
    parameter int RATE_W = 12,
    parameter int LEN_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RATE_W-1:0] rate_cfg,
    input logic              rd_req_valid,
    input logic [LEN_W-1:0]  rd_req_len,
    input logic              rd_req_ready,
    input logic              rd_dn_valid,
    input logic              rd_dn_ready,
    input logic [LEN_W-1:0]  credit
);
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_cfg == '0) |-> (rd_req_ready == rd_dn_ready && rd_dn_valid == rd_req_valid));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && rd_req_ready && rate_cfg != '0 && rd_req_len != '0 && credit == '0)
        |=> (credit == $past(rd_req_len)));

    p_hold_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (credit != '0 && rate_cfg != '0) |-> (!rd_req_ready && !rd_dn_valid));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (credit != '0 && rate_cfg != '0)
        |=> (credit == $past(credit) || credit == $past(credit) - LEN_W'(1)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_cfg == '0) |=> (credit == '0));
endmodule

bind rd_rate_limiter rrl_checker #(.RATE_W(RATE_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate_cfg     (rate_cfg),
    .rd_req_valid (rd_req_valid),
    .rd_req_len   (rd_req_len),
    .rd_req_ready (rd_req_ready),
    .rd_dn_valid  (rd_dn_valid),
    .rd_dn_ready  (rd_dn_ready),
    .credit       (credit)
);

// File: tb/test_rd_rate_limiter.sv
`timescale 1ns/1ps
module test_rd_rate_limiter;
    localparam int RATE_W = 12;
    localparam int LEN_W  = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RATE_W-1:0] rate_cfg = '0;
    logic              tick = 1'b1;
    logic              rd_req_valid = 1'b0;
    logic [LEN_W-1:0]  rd_req_len = '0;
    logic              rd_req_ready;
    logic              rd_dn_valid;
    logic [LEN_W-1:0]  rd_dn_len;
    logic              rd_dn_ready = 1'b1;

    int    tests = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R9";

    // behavioural reference state
    int m_credit = 0;
    int m_presc  = 0;
    int m_rate   = 0;
    bit m_open;

    always #4 clk = ~clk;

    rd_rate_limiter #(.RATE_W(RATE_W), .LEN_W(LEN_W)) i_rd_rate_limiter (
        .clk(clk), .rst_n(rst_n), .rate_cfg(rate_cfg), .tick(tick),
        .rd_req_valid(rd_req_valid), .rd_req_len(rd_req_len),
        .rd_req_ready(rd_req_ready), .rd_dn_valid(rd_dn_valid),
        .rd_dn_len(rd_dn_len), .rd_dn_ready(rd_dn_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_credit = 0; m_presc = 0; m_rate = 0;
        end else begin
            m_open = (m_credit == 0) || (rate_cfg == 0);
            if (rate_cfg == 0) begin
                m_credit = 0; m_presc = 0;
            end else if (m_credit == 0) begin
                if (rd_req_valid && rd_dn_ready && m_open && rd_req_len != 0) begin
                    m_credit = rd_req_len; m_presc = 0; m_rate = rate_cfg;
                end
            end else if (tick) begin
                if (m_presc + 1 == m_rate) begin
                    m_credit = m_credit - 1; m_presc = 0; m_rate = rate_cfg;
                end else begin
                    m_presc = m_presc + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            m_open = (m_credit == 0) || (rate_cfg == 0);
            chk({cur_req, " cycle ready"}, int'(rd_req_ready), int'(rd_dn_ready && m_open));
            chk({cur_req, " cycle dn_valid"}, int'(rd_dn_valid), int'(rd_req_valid && m_open));
        end
    end

    task automatic start_req(input int len, input string tag);
        @(posedge clk); #1;
        rd_req_valid = 1'b1;
        rd_req_len = LEN_W'(len);
        @(negedge clk);
        chk({tag, " ready before accept"}, int'(rd_req_ready), 1);
        @(posedge clk); #1;
        rd_req_valid = 1'b0;
    endtask

    task automatic measure_hold(output int n, input int sw_at, input int sw_rate);
        n = 0;
        for (int guard = 0; guard < 20000; guard++) begin
            @(negedge clk);
            if (rd_req_ready) break;
            n++;
            if (n == sw_at) rate_cfg = RATE_W'(sw_rate);
        end
    endtask

    initial begin
        int n;
        int low;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R9";
        chk("R9 ready after reset", int'(rd_req_ready), 1);
        chk("R9 dn_valid after reset", int'(rd_dn_valid), 0);

        // R1: throttling off, requests pass back to back
        cur_req = "R1";
        @(posedge clk); #1;
        rd_req_valid = 1'b1; rd_req_len = 11'd8;
        repeat (5) begin
            @(negedge clk);
            chk("R1 ready stays high", int'(rd_req_ready), 1);
        end
        rd_dn_ready = 1'b0; #1;
        chk("R1 ready follows downstream", int'(rd_req_ready), 0);
        chk("R1 dn_valid follows request", int'(rd_dn_valid), 1);
        @(posedge clk); #1;
        rd_dn_ready = 1'b1; rd_req_valid = 1'b0;

        // R2 / R4: basic hold L*R
        cur_req = "R4";
        rate_cfg = 12'd3;
        start_req(5, "R2");
        #1 chk("R2 ready low after accept", int'(rd_req_ready), 0);
        measure_hold(n, -1, 0);
        chk("R4 hold 5x3", n, 15);

        // R10: immediate follow-on request gets a full hold
        cur_req = "R10";
        start_req(4, "R10");
        measure_hold(n, -1, 0);
        chk("R10 back-to-back hold 4x3", n, 12);

        cur_req = "R4";
        rate_cfg = 12'd1;
        start_req(1, "R4");
        measure_hold(n, -1, 0);
        chk("R4 hold 1x1", n, 1);
        start_req(1024, "R4");
        measure_hold(n, -1, 0);
        chk("R4 hold 1024x1", n, 1024);
        rate_cfg = 12'd1000;
        start_req(2, "R4");
        measure_hold(n, -1, 0);
        chk("R4 hold 2x1000", n, 2000);

        // R3: valid during hold is blocked
        cur_req = "R3";
        rate_cfg = 12'd2;
        start_req(4, "R3");
        @(negedge clk);
        rd_req_valid = 1'b1; #1;
        chk("R3 dn_valid blocked", int'(rd_dn_valid), 0);
        chk("R3 ready blocked", int'(rd_req_ready), 0);
        rd_req_valid = 1'b0;
        measure_hold(n, -1, 0);
        chk("R3 remaining hold", n, 7);

        // R6: zero-length request
        cur_req = "R6";
        start_req(0, "R6");
        @(negedge clk);
        chk("R6 no hold on zero length", int'(rd_req_ready), 1);

        // R5: ticks low freeze the drain
        cur_req = "R5";
        rate_cfg = 12'd3;
        tick = 1'b0;
        start_req(2, "R5");
        low = 0;
        repeat (40) begin
            @(negedge clk);
            if (!rd_req_ready) low++;
        end
        chk("R5 held while tick low", low, 40);
        @(posedge clk); #1 tick = 1'b1;
        measure_hold(n, -1, 0);
        chk("R5 hold after tick resumes", n, 6);

        // R7: rate change mid-hold
        cur_req = "R7";
        rate_cfg = 12'd4;
        start_req(3, "R7");
        measure_hold(n, 2, 1);
        chk("R7 hold with rate 4 then 1", n, 6);

        // R8: disable during hold
        cur_req = "R8";
        rate_cfg = 12'd5;
        start_req(10, "R8");
        measure_hold(n, 3, 0);
        chk("R8 released on disable", n, 3);
        rate_cfg = 12'd5; #1;
        repeat (3) begin
            @(negedge clk);
            chk("R8 no resume after re-enable", int'(rd_req_ready), 1);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule